// File: doc/BRIEF.md
# Serial EEPROM Erase-All Command Engine

This block is the device side of a three-wire serial EEPROM interface, cut down to the single command that clears the whole array. A host selects the device, clocks in a start bit, an opcode and an address field, and deselects. The block recognises the erase-all frame and runs a self-timed erase. The erase sets every word of the array to all ones through a plain internal write port, one word per system clock.

While the erase runs, the host can poll progress. It leaves chip select low for a minimum time and raises it again. The block then drives the serial output low while busy and high once ready. Clocking in a new start bit hides that indication, and deselecting after the start bit clears it. The serial clock, data in and chip select are sampled into the system clock domain. All timing is counted in system clock cycles.

A parameter chooses when the erase starts:
- On the fall of chip select after a complete frame (the default).
- On the serial clock rise that delivers the next-to-last frame bit.

Top module: `eral_engine`

## Requirements
- R1: An accepted erase writes all ones to every word address from 0 to 2^ADDR_W-1. It writes one word per system cycle in ascending order, with no gap.
- R2: In the default mode the erase launches when chip select falls after a complete frame. It needs no serial clock edge after that fall.
- R3: The frame is a start bit 1, an opcode 00, and an ADDR_W-bit address field whose first two bits are 10 and whose other bits are ignored. A frame that differs in the opcode or in those two bits launches nothing.
- R4: A frame cut short by chip select falling before all its bits have arrived launches nothing.
- R5: Zero bits clocked in before the first 1 while chip select is high are idle bits and do not shift the frame.
- R6: After an erase has been accepted, raising chip select after at least MIN_CSL_CYC cycles of low time drives the output. The output is low while the erase is in progress. It is high from the cycle after the last word has been written.
- R7: A chip-select rise after fewer than MIN_CSL_CYC low cycles leaves the output at high impedance.
- R8: A start bit followed by a chip-select fall clears the status. Later chip-select rises leave the output at high impedance until the next erase is accepted.
- R9: The output enable is 0 after reset, while chip select is low, and once a start bit has been received in the current selection.
- R10: The first word write occurs BUSY_CYC+3 system cycles after chip select is driven low at the input. This covers two synchronizer stages, one launch cycle and BUSY_CYC busy cycles.
- R11: With EARLY_START=1 the erase launches on the rise that delivers the next-to-last frame bit. It completes while chip select is still high and no more clocks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in, sampled on serial clock rise |
| do_o | output | 1 | Serial data out value: 0 busy, 1 ready |
| do_oe_o | output | 1 | Output enable for do_o; 0 means high impedance |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array word address |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
Each input passes through two synchronizer flops before any decision. A chip-select fall therefore reaches the launch logic at the third clock edge, and the first write appears BUSY_CYC cycles later. A status rise becomes visible one edge after the synchronized rise. The bench drives inputs on falling clock edges. It runs a behavioural model on the same rising edges and compares enable, status, write strobe and address at every falling edge, so every result is checked in exactly the cycle it is due. The directed checks on the launch delay, the ignored frames and the cleared status wait several cycles beyond the due cycle before they sample.

// File: rtl/eral_pkg.sv
package eral_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_SHIFT = 2'd1,
      RX_DONE  = 2'd2
   } rx_state_t;

   typedef enum logic [1:0] {
      ER_IDLE  = 2'd0,
      ER_WAIT  = 2'd1,
      ER_WRITE = 2'd2
   } er_state_t;

   // opcode 00 followed by address lead 10, in arrival order
   localparam logic [3:0] ERAL_HEAD = 4'b0010;

endpackage

// File: rtl/eral_sync.sv
module eral_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("eral_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= d_i;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[i] <= '0;
         else        stage_q[i] <= stage_q[i-1];
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/eral_cmd_rx.sv
module eral_cmd_rx
   import eral_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_s,
   input  logic sk_rise,
   input  logic di_s,
   output logic start_seen,
   output logic frame_ok,
   output logic early_hit
);

   localparam int FRAME_W = 2 + ADDR_W;
   localparam int CW      = $clog2(FRAME_W + 1);
   localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_W - 1);
   localparam logic [CW-1:0] EARLY_IDX = CW'(FRAME_W - 2);

   rx_state_t          st_q;
   logic [CW-1:0]      cnt_q;
   logic [FRAME_W-1:0] sh_q;
   logic [FRAME_W-1:0] sh_nx;

   assign sh_nx = {sh_q[FRAME_W-2:0], di_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= RX_IDLE;
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (!cs_s) begin
         st_q  <= RX_IDLE;
         cnt_q <= '0;
      end else if (sk_rise) begin
         unique case (st_q)
            RX_IDLE: begin
               if (di_s) begin
                  st_q  <= RX_SHIFT;
                  cnt_q <= '0;
               end
            end
            RX_SHIFT: begin
               sh_q  <= sh_nx;
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST_IDX) st_q <= RX_DONE;
            end
            default: ;
         endcase
      end
   end

   assign start_seen = (st_q != RX_IDLE);
   assign frame_ok   = (st_q == RX_DONE) && (sh_q[FRAME_W-1 -: 4] == ERAL_HEAD);
   assign early_hit  = cs_s && sk_rise && (st_q == RX_SHIFT) && (cnt_q == EARLY_IDX)
                       && (sh_nx[FRAME_W-2 -: 4] == ERAL_HEAD);

endmodule

// File: rtl/eral_seq.sv
module eral_seq
   import eral_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int BUSY_CYC = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr
);

   localparam int BW = $clog2(BUSY_CYC + 1);
   localparam logic [BW-1:0]     WAIT_END = BW'(BUSY_CYC - 1);
   localparam logic [ADDR_W-1:0] ADDR_END = '1;

   er_state_t      st_q;
   logic [BW-1:0]  wcnt_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ER_IDLE;
         wcnt_q <= '0;
         addr_q <= '0;
      end else begin
         unique case (st_q)
            ER_IDLE: begin
               if (launch) begin
                  st_q   <= ER_WAIT;
                  wcnt_q <= '0;
               end
            end
            ER_WAIT: begin
               if (wcnt_q == WAIT_END) begin
                  st_q   <= ER_WRITE;
                  addr_q <= '0;
               end else begin
                  wcnt_q <= wcnt_q + 1'b1;
               end
            end
            ER_WRITE: begin
               if (addr_q == ADDR_END) st_q <= ER_IDLE;
               else                    addr_q <= addr_q + 1'b1;
            end
            default: st_q <= ER_IDLE;
         endcase
      end
   end

   assign busy     = (st_q != ER_IDLE);
   assign mem_we   = (st_q == ER_WRITE);
   assign mem_addr = addr_q;

endmodule

// File: rtl/eral_status.sv
module eral_status #(
   parameter int MIN_CSL_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_s,
   input  logic cs_rise,
   input  logic cs_fall,
   input  logic launch,
   input  logic start_seen,
   input  logic frame_ok,
   input  logic busy,
   output logic do_o,
   output logic do_oe
);

   localparam int LW = $clog2(MIN_CSL_CYC + 1);
   localparam logic [LW-1:0] LOW_MIN = LW'(MIN_CSL_CYC);

   logic [LW-1:0] low_q;
   logic          show_q;
   logic          armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q   <= '0;
         show_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (cs_s)                 low_q <= '0;
         else if (low_q < LOW_MIN) low_q <= low_q + 1'b1;

         if (cs_rise) show_q <= (low_q >= LOW_MIN);

         if (launch)                                  armed_q <= 1'b1;
         else if (cs_fall && start_seen && !frame_ok) armed_q <= 1'b0;
      end
   end

   assign do_oe = cs_s && show_q && armed_q && !start_seen;
   assign do_o  = !busy;

endmodule

// File: rtl/eral_engine.sv
module eral_engine #(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int MIN_CSL_CYC = 4,
   parameter int BUSY_CYC    = 20,
   parameter int SYNC_STAGES = 2,
   parameter bit EARLY_START = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              sk_i,
   input  logic              di_i,
   output logic              do_o,
   output logic              do_oe_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o
);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("eral_engine: ADDR_W must be at least 3");
   end
   if (MIN_CSL_CYC < 1) begin : g_bad_csl
      $error("eral_engine: MIN_CSL_CYC must be at least 1");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("eral_engine: BUSY_CYC must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("eral_engine: DATA_W must be at least 1");
   end

   logic [2:0] pins_s;
   logic       cs_s, sk_s, di_s;
   logic       cs_d, sk_d;
   logic       cs_rise, cs_fall, sk_rise;
   logic       start_seen, frame_ok, early_hit;
   logic       go, launch, busy;

   eral_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({cs_i, sk_i, di_i}),
      .q_o   (pins_s)
   );

   assign cs_s = pins_s[2];
   assign sk_s = pins_s[1];
   assign di_s = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d <= 1'b0;
         sk_d <= 1'b0;
      end else begin
         cs_d <= cs_s;
         sk_d <= sk_s;
      end
   end

   assign cs_rise = cs_s && !cs_d;
   assign cs_fall = !cs_s && cs_d;
   assign sk_rise = sk_s && !sk_d;

   eral_cmd_rx #(.ADDR_W(ADDR_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_s       (cs_s),
      .sk_rise    (sk_rise),
      .di_s       (di_s),
      .start_seen (start_seen),
      .frame_ok   (frame_ok),
      .early_hit  (early_hit)
   );

   if (EARLY_START) begin : g_go_early
      assign go = early_hit;
   end else begin : g_go_deselect
      assign go = cs_fall && frame_ok;
   end

   assign launch = go && !busy;

   eral_seq #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .busy     (busy),
      .mem_we   (mem_we_o),
      .mem_addr (mem_addr_o)
   );

   eral_status #(.MIN_CSL_CYC(MIN_CSL_CYC)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_s       (cs_s),
      .cs_rise    (cs_rise),
      .cs_fall    (cs_fall),
      .launch     (launch),
      .start_seen (start_seen),
      .frame_ok   (frame_ok),
      .busy       (busy),
      .do_o       (do_o),
      .do_oe      (do_oe_o)
   );

   assign mem_wdata_o = '1;

endmodule

// File: rtl/eral_chk.sv
module eral_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_s,
   input logic              launch,
   input logic              busy,
   input logic              do_o,
   input logic              do_oe_o,
   input logic              mem_we_o,
   input logic [ADDR_W-1:0] mem_addr_o
);

   localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

   AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1)); // R1

   AST_STOP_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_o) |-> ($past(mem_addr_o) == TOP_ADDR)); // R1

   AST_OE_OFF_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_s) |-> !do_oe_o); // R9

   AST_LOW_WHILE_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
      (do_oe_o && mem_we_o) |-> !do_o); // R6

   AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && mem_addr_o == TOP_ADDR) |=> !busy); // R6

   AST_LAUNCH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (busy && !mem_we_o)); // R10

endmodule

bind eral_engine eral_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_s       (cs_s),
   .launch     (launch),
   .busy       (busy),
   .do_o       (do_o),
   .do_oe_o    (do_oe_o),
   .mem_we_o   (mem_we_o),
   .mem_addr_o (mem_addr_o)
);

// File: tb/eral_engine_tb.sv
module eral_engine_tb;

   localparam int ADDR_W = 4;
   localparam int DATA_W = 8;
   localparam int MINL   = 4;
   localparam int BUSY   = 20;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int FW     = 2 + ADDR_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sk = 1'b0, di = 1'b0;
   logic do_v, do_oe, we;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] wdata;
   logic e_do, e_oe, e_we;
   logic [ADDR_W-1:0] e_addr;
   logic [DATA_W-1:0] e_wdata;

   always #10 clk = ~clk;

   eral_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_CSL_CYC(MINL),
                 .BUSY_CYC(BUSY), .EARLY_START(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
      .do_o(do_v), .do_oe_o(do_oe), .mem_we_o(we), .mem_addr_o(addr),
      .mem_wdata_o(wdata));

   eral_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_CSL_CYC(MINL),
                 .BUSY_CYC(BUSY), .EARLY_START(1'b1)) u_early (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
      .do_o(e_do), .do_oe_o(e_oe), .mem_we_o(e_we), .mem_addr_o(e_addr),
      .mem_wdata_o(e_wdata));

   int n_chk = 0, n_bad = 0;
   int cyc = 0, wr_cnt = 0, ewr_cnt = 0;
   bit done = 0;
   logic [DATA_W-1:0] mem [DEPTH];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (we) begin
            mem[addr] <= wdata;
            wr_cnt++;
         end
         if (e_we) ewr_cnt++;
      end
   end

   // behavioural reference model of the default-mode instance
   int m_c1, m_c2, m_k1, m_k2, m_d1, m_d2, m_cd, m_kd;
   int m_rx, m_n, m_bits, m_low, m_show, m_arm, m_er, m_ec, m_ea;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_c1 = 0; m_c2 = 0; m_k1 = 0; m_k2 = 0; m_d1 = 0; m_d2 = 0;
         m_cd = 0; m_kd = 0; m_rx = 0; m_n = 0; m_bits = 0;
         m_low = 0; m_show = 0; m_arm = 0; m_er = 0; m_ec = 0; m_ea = 0;
      end else begin
         int c, k, d, rise, fall, crise, started, complete, launch;
         c = m_c2; k = m_k2; d = m_d2;
         rise = k && !m_kd; fall = !c && m_cd; crise = c && !m_cd;
         started = (m_rx != 0);
         complete = (m_rx == 2) && (((m_bits >> (FW - 4)) & 15) == 2);
         launch = fall && complete && (m_er == 0);
         m_c2 = m_c1; m_c1 = int'(cs);
         m_k2 = m_k1; m_k1 = int'(sk);
         m_d2 = m_d1; m_d1 = int'(di);
         m_cd = c; m_kd = k;
         if (!c) begin
            m_rx = 0; m_n = 0;
         end else if (rise) begin
            if (m_rx == 0) begin
               if (d) begin m_rx = 1; m_n = 0; end
            end else if (m_rx == 1) begin
               m_bits = ((m_bits << 1) | d) & ((1 << FW) - 1);
               if (m_n == FW - 1) m_rx = 2;
               m_n++;
            end
         end
         if (crise) m_show = (m_low >= MINL);
         if (c) m_low = 0; else if (m_low < MINL) m_low++;
         if (launch) m_arm = 1;
         else if (fall && started && !complete) m_arm = 0;
         if (m_er == 0) begin
            if (launch) begin m_er = 1; m_ec = 0; end
         end else if (m_er == 1) begin
            if (m_ec == BUSY - 1) begin m_er = 2; m_ea = 0; end else m_ec++;
         end else begin
            if (m_ea == DEPTH - 1) m_er = 0; else m_ea++;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int x_oe;
         x_oe = (m_c2 && m_show && m_arm && m_rx == 0) ? 1 : 0;
         check(int'(do_oe) == x_oe, "R9 model enable", int'(do_oe), x_oe);
         if (x_oe == 1) check(int'(do_v) == int'(m_er == 0), "R6 model status",
                              int'(do_v), int'(m_er == 0));
         check(int'(we) == int'(m_er == 2), "R1 model strobe", int'(we), int'(m_er == 2));
         if (m_er == 2) check(int'(addr) == m_ea, "R1 model address", int'(addr), m_ea);
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk) di = b;
      wait_n(2);
      sk = 1'b1;
      wait_n(3);
      sk = 1'b0;
      wait_n(2);
   endtask

   task automatic send_bits(input int n, input logic [31:0] v);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_run();
   end

   initial begin
      int base, ebase, t0, ones;
      wait_n(4);
      rst_n = 1'b1;
      wait_n(1);
      check(do_oe == 1'b0, "R9 reset enable", int'(do_oe), 0);
      check(we == 1'b0, "R9 reset strobe", int'(we), 0);

      // R5: idle zeros then a full erase frame, address tail 01
      cs = 1'b1; wait_n(4);
      base = wr_cnt;
      send_bits(2, 32'b00);
      send_bits(7, 32'b1_00_1001);
      @(negedge clk) cs = 1'b0;
      wait_n(8);
      cs = 1'b1; wait_n(4);
      check(do_oe == 1'b1 && do_v == 1'b0, "R6 busy poll", int'({do_oe, do_v}), 2);
      wait_n(40);
      check(do_oe == 1'b1 && do_v == 1'b1, "R6 ready poll", int'({do_oe, do_v}), 3);
      check(wr_cnt - base == DEPTH, "R5 R2 erase count", wr_cnt - base, DEPTH);
      ones = 0;
      for (int i = 0; i < DEPTH; i++) if (mem[i] == '1) ones++;
      check(ones == DEPTH, "R1 all words ones", ones, DEPTH);

      // R9 then R8: start bit hides status, deselect clears it
      base = wr_cnt;
      send_bit(1'b1);
      wait_n(1);
      check(do_oe == 1'b0, "R9 start bit hides", int'(do_oe), 0);
      cs = 1'b0; wait_n(10);
      cs = 1'b1; wait_n(5);
      check(do_oe == 1'b0, "R8 status cleared", int'(do_oe), 0);
      cs = 1'b0; wait_n(40);
      check(wr_cnt == base, "R4 lone start bit", wr_cnt - base, 0);

      // R3: wrong opcode, then wrong address lead
      cs = 1'b1; wait_n(3);
      send_bits(7, 32'b1_01_1000);
      cs = 1'b0; wait_n(50);
      check(wr_cnt == base, "R3 opcode 01", wr_cnt - base, 0);
      cs = 1'b1; wait_n(3);
      send_bits(7, 32'b1_00_1100);
      cs = 1'b0; wait_n(50);
      check(wr_cnt == base, "R3 lead 11", wr_cnt - base, 0);

      // R7 and R10: short low time, then launch delay
      cs = 1'b1; wait_n(3);
      send_bits(7, 32'b1_00_1010);
      @(negedge clk) cs = 1'b0;
      t0 = cyc;
      wait_n(2);
      cs = 1'b1; wait_n(4);
      check(do_oe == 1'b0, "R7 short low", int'(do_oe), 0);
      while (!we) @(negedge clk);
      check(cyc - t0 == BUSY + 3, "R10 launch delay", cyc - t0, BUSY + 3);
      wait_n(DEPTH + 2);
      cs = 1'b0; wait_n(8);
      cs = 1'b1; wait_n(4);
      check(do_oe == 1'b1 && do_v == 1'b1, "R6 ready after long low", int'({do_oe, do_v}), 3);

      // R11 and R4: early variant launches mid-frame, default aborts
      cs = 1'b0; wait_n(6);
      cs = 1'b1; wait_n(3);
      base = wr_cnt; ebase = ewr_cnt;
      send_bits(6, 32'b1_00_100);
      wait_n(50);
      check(ewr_cnt - ebase == DEPTH, "R11 early erase", ewr_cnt - ebase, DEPTH);
      check(wr_cnt == base, "R2 no launch while selected", wr_cnt - base, 0);
      cs = 1'b0; wait_n(50);
      check(wr_cnt == base, "R4 aborted frame", wr_cnt - base, 0);

      finish_run();
   end

endmodule